// File: doc/BRIEF.md
# Transmit Deferral Watchdog

This block sits beside an Ethernet MAC transmitter. It decides when a frame that is ready may go onto the medium, and it limits how long the transmitter waits for a busy medium. A wait starts when a frame is ready but carrier sense says the medium is busy. While the block waits, it counts bit-time ticks. If the check is armed and one wait goes past 24,288 bit times, the block gives up on the attempt and emits a one-cycle abort pulse.

A wait never carries over into the next one. When the medium frees, the block grants transmission and clears the count. When an external back-off finishes, the count also returns to zero, so a fresh wait after a collision starts from nothing. With the check disarmed, the block waits as long as carrier sense stays high. With the transmitter disabled, it grants nothing.

Top module: `txdefer_guard`

## Requirements
- R1: After reset the grant and abort outputs are low and the wait count is zero.
- R2: With `tx_on` high and `frame_rdy` high, a busy medium (`crs` high) starts a wait. A free medium, or the end of a wait when `crs` falls, raises `tx_grant` in the cycle after the clock edge that samples the condition.
- R3: The wait count advances by one only on a clock edge where `bit_tick` is high while the block is waiting. Clock cycles without a tick leave it unchanged.
- R4: With `chk_on` high, a wait of exactly 24,288 ticks produces no abort. The 24,289th tick raises `defer_abort` in the cycle after the edge that samples it.
- R5: `defer_abort` lasts one cycle. The block then returns to idle with `tx_grant` low.
- R6: A `backoff_done` pulse while waiting clears the count, and a grant also clears it. A new wait after a collision and back-off therefore gets a full 24,288 ticks of its own.
- R7: With `chk_on` low, no abort occurs however long `crs` stays high, and the grant still follows once `crs` falls.
- R8: With `tx_on` low, `tx_grant` stays low. Dropping `tx_on` removes a grant on the next cycle.
- R9: `tx_grant` stays high until `frame_rdy` falls, and then drops on the next cycle.
- R10: The count saturates above the limit and does not wrap. Raising `chk_on` during a wait that is already over the limit gives an immediate abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle strobe per bit time |
| crs | input | 1 | Carrier sense, medium busy |
| frame_rdy | input | 1 | Transmitter holds a frame to send |
| backoff_done | input | 1 | Pulse when the collision back-off finishes |
| chk_on | input | 1 | Arms the deferral limit |
| tx_on | input | 1 | Transmitter enable |
| tx_grant | output | 1 | Transmission may proceed |
| defer_abort | output | 1 | One-cycle pulse when the wait limit is exceeded |

## Verification
The hardest case to reach is proving that a wait is not cumulative. The stimulus has to build up a large partial wait, pass through a grant and a collision, wait again, clear the count with a back-off pulse mid-wait, and then run a full limit's worth of ticks. It must show both that no abort occurs and that the very next tick does abort. The directed scenario drives that whole chain with one tick per clock, which keeps the run short while still going tens of thousands of bit times past the limit in total.

// File: rtl/txdefer_pkg.sv
package txdefer_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_SEND  = 2'd2
  } dstate_e;

endpackage

// File: rtl/defer_count.sv
module defer_count #(
  parameter int LIMIT = 24288
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            clr,
  input  logic                            inc,
  output logic                            over,
  output logic [$clog2(LIMIT + 2) - 1:0]  cnt
);

  localparam int CW = $clog2(LIMIT + 2);
  localparam logic [CW-1:0] SAT = CW'(LIMIT + 1);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = clr | (inc & (cnt_q != SAT));
    if (clr) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign over = (cnt_q == SAT);
  assign cnt  = cnt_q;

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= SAT);  // R10

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !clr && cnt_q != SAT) |=> (cnt_q == $past(cnt_q) + CW'(1)));  // R3

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!inc && !clr) |=> $stable(cnt_q));  // R3

endmodule

// File: rtl/defer_ctrl.sv
module defer_ctrl
  import txdefer_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    crs,
  input  logic    frame_rdy,
  input  logic    chk_on,
  input  logic    tx_on,
  input  logic    cnt_over,
  output dstate_e state_q,
  output dstate_e state_d,
  output logic    abort
);

  logic want;

  assign want  = tx_on & frame_rdy;
  assign abort = (state_q == ST_WAIT) & chk_on & cnt_over;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (want) begin
          state_d = crs ? ST_WAIT : ST_SEND;
        end
      end
      ST_WAIT: begin
        if (!want || abort) begin
          state_d = ST_IDLE;
        end else if (!crs) begin
          state_d = ST_SEND;
        end
      end
      ST_SEND: begin
        if (!want) begin
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  AST_OFF_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_on |=> (state_q == ST_IDLE));  // R8

  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (state_q == ST_IDLE));  // R5

  AST_UNCHECKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !chk_on |-> !abort);  // R7

endmodule

// File: rtl/txdefer_guard.sv
module txdefer_guard
  import txdefer_pkg::*;
#(
  parameter int LIMIT = 24288
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_tick,
  input  logic crs,
  input  logic frame_rdy,
  input  logic backoff_done,
  input  logic chk_on,
  input  logic tx_on,
  output logic tx_grant,
  output logic defer_abort
);

  localparam int CW = $clog2(LIMIT + 2);

  dstate_e       st_q;
  dstate_e       st_d;
  logic          over;
  logic          clr;
  logic          inc;
  logic          abort_w;
  logic [CW-1:0] cnt;

  defer_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .crs       (crs),
    .frame_rdy (frame_rdy),
    .chk_on    (chk_on),
    .tx_on     (tx_on),
    .cnt_over  (over),
    .state_q   (st_q),
    .state_d   (st_d),
    .abort     (abort_w)
  );

  assign clr = (st_d != ST_WAIT) | backoff_done;
  assign inc = bit_tick & (st_q == ST_WAIT);

  defer_count #(.LIMIT(LIMIT)) u_cnt (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (clr),
    .inc   (inc),
    .over  (over),
    .cnt   (cnt)
  );

  assign tx_grant    = (st_q == ST_SEND) & tx_on;
  assign defer_abort = abort_w;

  AST_ABORT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    defer_abort |=> !defer_abort);  // R5

  AST_GRANT_ZERO_CNT: assert property (@(posedge clk) disable iff (!rst_n)
    tx_grant |-> (cnt == '0));  // R6

  AST_BACKOFF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    backoff_done |=> (cnt == '0));  // R6

  AST_ABORT_NEEDS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    defer_abort |-> (cnt > CW'(LIMIT)));  // R4

endmodule

// File: tb/sim_txdefer_guard.sv
module sim_txdefer_guard;

  localparam int CLK_PERIOD = 10;
  localparam int LIM        = 24288;

  logic clk;
  logic rst_n;
  logic bit_tick;
  logic crs;
  logic frame_rdy;
  logic backoff_done;
  logic chk_on;
  logic tx_on;
  logic tx_grant;
  logic defer_abort;

  int n_chk;
  int n_err;
  int abort_cnt;
  int grant_cnt;
  bit done;

  txdefer_guard #(.LIMIT(LIM)) u0 (
    .clk          (clk),
    .rst_n        (rst_n),
    .bit_tick     (bit_tick),
    .crs          (crs),
    .frame_rdy    (frame_rdy),
    .backoff_done (backoff_done),
    .chk_on       (chk_on),
    .tx_on        (tx_on),
    .tx_grant     (tx_grant),
    .defer_abort  (defer_abort)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && defer_abort) abort_cnt++;
    if (rst_n && tx_grant) grant_cnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1'b1;
      step();
    end
    bit_tick = 1'b0;
  endtask

  task automatic quiet();
    frame_rdy = 1'b0;
    crs       = 1'b0;
    step();
    step();
  endtask

  task automatic t_exact();
    int base;
    base = abort_cnt;
    frame_rdy = 1'b1;
    crs       = 1'b1;
    step();
    run_ticks(LIM);
    repeat (5) step();
    chk(abort_cnt == base, "R4 exact limit no abort", abort_cnt - base, 0);
    chk(tx_grant == 1'b0, "R2 no grant while busy", tx_grant, 0);
    crs = 1'b0;
    step();
    chk(tx_grant == 1'b1, "R2 grant after carrier drop", tx_grant, 1);
    repeat (10) step();
    chk(tx_grant == 1'b1, "R9 grant held", tx_grant, 1);
    frame_rdy = 1'b0;
    step();
    chk(tx_grant == 1'b0, "R9 grant drops", tx_grant, 0);
    quiet();
  endtask

  task automatic t_over();
    int base;
    base = abort_cnt;
    frame_rdy = 1'b1;
    crs       = 1'b1;
    step();
    run_ticks(LIM);
    repeat (200) step();
    chk(abort_cnt == base, "R3 no count without tick", abort_cnt - base, 0);
    run_ticks(1);
    chk(defer_abort == 1'b1, "R4 abort on tick past limit", defer_abort, 1);
    step();
    chk(defer_abort == 1'b0, "R5 abort one cycle", defer_abort, 0);
    chk(tx_grant == 1'b0, "R5 no grant after abort", tx_grant, 0);
    chk(abort_cnt == base + 1, "R5 single abort pulse", abort_cnt - base, 1);
    quiet();
  endtask

  task automatic t_backoff();
    int base;
    base = abort_cnt;
    frame_rdy = 1'b1;
    crs       = 1'b1;
    step();
    run_ticks(10000);
    crs = 1'b0;
    step();
    chk(tx_grant == 1'b1, "R6 grant after 10000 tick wait", tx_grant, 1);
    frame_rdy = 1'b0;
    crs       = 1'b1;
    step();
    chk(tx_grant == 1'b0, "R9 grant gone on collision", tx_grant, 0);
    frame_rdy = 1'b1;
    step();
    run_ticks(20000);
    backoff_done = 1'b1;
    step();
    backoff_done = 1'b0;
    run_ticks(LIM);
    repeat (3) step();
    chk(abort_cnt == base, "R6 wait restarts from zero", abort_cnt - base, 0);
    run_ticks(1);
    chk(defer_abort == 1'b1, "R6 abort after full fresh wait", defer_abort, 1);
    step();
    quiet();
  endtask

  task automatic t_nolimit();
    int base;
    base   = abort_cnt;
    chk_on = 1'b0;
    frame_rdy = 1'b1;
    crs       = 1'b1;
    step();
    run_ticks(30000);
    repeat (3) step();
    chk(abort_cnt == base, "R7 no abort when unchecked", abort_cnt - base, 0);
    chk(tx_grant == 1'b0, "R7 still waiting", tx_grant, 0);
    chk_on = 1'b1;
    #1;
    chk(defer_abort == 1'b1, "R10 saturated count aborts on arm", defer_abort, 1);
    step();
    quiet();
    chk_on = 1'b0;
    frame_rdy = 1'b1;
    crs       = 1'b1;
    step();
    run_ticks(50);
    crs = 1'b0;
    step();
    chk(tx_grant == 1'b1, "R7 grant when unchecked", tx_grant, 1);
    chk_on = 1'b1;
    quiet();
  endtask

  task automatic t_txoff();
    int gbase;
    tx_on     = 1'b0;
    frame_rdy = 1'b1;
    crs       = 1'b0;
    gbase     = grant_cnt;
    repeat (20) step();
    chk(grant_cnt == gbase, "R8 no grant while disabled", grant_cnt - gbase, 0);
    tx_on = 1'b1;
    step();
    chk(tx_grant == 1'b1, "R8 grant once enabled", tx_grant, 1);
    tx_on = 1'b0;
    step();
    chk(tx_grant == 1'b0, "R8 grant removed", tx_grant, 0);
    tx_on = 1'b1;
    quiet();
  endtask

  initial begin
    n_chk = 0;
    n_err = 0;
    abort_cnt = 0;
    grant_cnt = 0;
    done = 1'b0;
    rst_n = 1'b0;
    bit_tick = 1'b0;
    crs = 1'b0;
    frame_rdy = 1'b0;
    backoff_done = 1'b0;
    chk_on = 1'b1;
    tx_on = 1'b1;
    repeat (3) step();
    chk(tx_grant == 1'b0, "R1 reset grant", tx_grant, 0);
    chk(defer_abort == 1'b0, "R1 reset abort", defer_abort, 0);
    rst_n = 1'b1;
    step();
    chk(tx_grant == 1'b0 && defer_abort == 1'b0, "R1 idle after reset", tx_grant, 0);
    t_exact();
    t_over();
    t_backoff();
    t_nolimit();
    t_txoff();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

endmodule